// File: doc/BRIEF.md
# Deferred-Shutdown PWM Output Guard

This block sits between a two-channel PWM timer core and the output pins. The core sends, for each channel, a set request (begin the active pulse) and a reset request (end it). The guard turns these into pin levels. It also watches an asynchronous external fault line. When delayed protection is enabled and a rising edge arrives on that line, each selected channel is parked at its idle level. A channel that is idle at that moment parks at once. A channel that is in the middle of an active pulse finishes that pulse first and parks on its next reset request. The timer core keeps counting the whole time. A parked channel keeps its enable bit set. Software releases it by writing 1 to that enable bit, and the pin then stays idle until the next set request.

Each channel runs its own four-state machine. `ST_OFF` means the channel is not enabled and the pin sits at its idle level. `ST_RUN` means normal PWM. `ST_ARMED` means a fault has been seen and the active pulse is still running. `ST_HOLD` means the channel is parked at its idle level. The transitions are as follows. OFF→RUN happens on an enable write. RUN→ARMED happens on a fault while the pulse is active. RUN→HOLD happens on a fault while the channel is inactive, or on a fault in the same cycle as a reset request. ARMED→HOLD happens on a reset request. HOLD→RUN happens on an enable write. Enable writes in ARMED are ignored.

Fault edges that pass the enable gate also set a sticky event flag. This flag feeds an interrupt/DMA request line. At the same moment, the pin levels of both channels are captured into a status register.

Top module: `pwm_delayed_idle`

## Requirements
- R1: After reset, `out_en` is 00, each pin `pwm_out[i]` equals `idle_lvl[i]`, and `evt_flag`, `irq` and `trip_stat` are 0.
- R2: A one-cycle `oen_wr` with `oen_data[i]`=1 enables channel i. While running, the pin equals `idle_lvl[i]` XOR the active bit. `set_req[i]` makes the channel active and `rst_req[i]` makes it inactive, with reset winning over set. Both take effect on the next clock edge. `pwm_copy` always equals `pwm_out`.
- R3: When `prot_en` is 0, a fault edge has no effect on the pins or on `evt_flag`.
- R4: Suppose a fault reaches a selected channel while its pulse is active. The pin stays active, and set requests and enable writes change nothing. The pin goes idle on the edge that takes the next reset request.
- R5: Suppose a fault reaches a selected channel while it is inactive, or in the same cycle as its reset request. The channel is idle from the next edge, and later set requests are ignored.
- R6: Entering or holding delayed idle leaves `out_en[i]` at 1.
- R7: In hold, an enable write with bit i set leaves the pin idle. The next set request makes it active.
- R8: `mode[1:0]` selects the channels hit by a fault: 00 selects channel 0, 01 selects channel 1, 10 selects both, and 11 selects neither. `mode[2]` has no effect.
- R9: The fault line passes through two synchronizer flops and a rising-edge detector. A rise that is present before clock edge k acts on edge k+2. A line that stays high acts once. The flag is set whether or not a pulse is in progress.
- R10: `evt_flag` is sticky until a `flag_clr` pulse clears it, and a new event in the same cycle wins over the clear. `irq` = `evt_flag` AND `irq_en`.
- R11: When a fault is accepted, `trip_stat` captures both pin levels as they were just before that edge, whatever `mode` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 2 | Per-channel request to start the active pulse |
| rst_req | input | 2 | Per-channel request to end the active pulse |
| fault_in | input | 1 | Asynchronous external fault line |
| prot_en | input | 1 | Enables delayed protection |
| mode | input | 3 | Channel selection for protection |
| idle_lvl | input | 2 | Per-channel idle pin level |
| oen_wr | input | 1 | Enable-write strobe |
| oen_data | input | 2 | Enable-write data (1 sets the bit) |
| flag_clr | input | 1 | Clears the event flag |
| irq_en | input | 1 | Interrupt/DMA request enable |
| pwm_out | output | 2 | Output pin levels |
| pwm_copy | output | 2 | Readable copy of the pin levels |
| out_en | output | 2 | Per-channel enable bits |
| evt_flag | output | 1 | Sticky protection event flag |
| irq | output | 1 | Interrupt/DMA request |
| trip_stat | output | 2 | Pin levels captured at the fault |

## Verification
The risky case is a fault edge that lands in the same cycle as a channel's reset request, its set request, or a flag clear. The bench produces each of these by raising `fault_in` and then driving the competing request just after the second clock edge, which is the cycle in which the synchronized edge is live. It then checks three things. The channel must end up parked rather than active. A later set request must not revive it. The flag must stay set. A sweep over every mode, idle level, starting active pattern and protection enable covers the remaining combinations.

// File: rtl/dip_pkg.sv
package dip_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_ARMED = 2'd2,
        ST_HOLD  = 2'd3
    } dip_state_e;

    localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dip_evt_sync.sv
module dip_evt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            last  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            last  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/dip_out_fsm.sv
module dip_out_fsm
    import dip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic rst_req,
    input  logic trip,
    input  logic en_wr,
    input  logic idle_lvl,
    output logic pin,
    output logic en
);
    dip_state_e st, st_nx;
    logic       act, act_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_OFF;
            act <= 1'b0;
        end else begin
            st  <= st_nx;
            act <= act_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        act_nx = act;
        unique case (st)
            ST_OFF: begin
                act_nx = 1'b0;
                if (en_wr) st_nx = ST_RUN;
            end
            ST_RUN: begin
                if (trip) begin
                    if (act && !rst_req) begin
                        st_nx = ST_ARMED;
                    end else begin
                        st_nx  = ST_HOLD;
                        act_nx = 1'b0;
                    end
                end else if (rst_req) begin
                    act_nx = 1'b0;
                end else if (set_req) begin
                    act_nx = 1'b1;
                end
            end
            ST_ARMED: begin
                if (rst_req) begin
                    st_nx  = ST_HOLD;
                    act_nx = 1'b0;
                end
            end
            ST_HOLD: begin
                act_nx = 1'b0;
                if (en_wr) st_nx = ST_RUN;
            end
            default: begin
                st_nx  = ST_OFF;
                act_nx = 1'b0;
            end
        endcase
    end

    // outputs
    always_comb begin
        pin = act ^ idle_lvl;
        en  = (st != ST_OFF);
    end

    a_r4_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && !rst_req) |=> (st == ST_ARMED && act));
    a_r4_armed_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && rst_req) |=> (st == ST_HOLD && !act));
    a_r5_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && set_req && !en_wr) |=> !act);
    a_r6_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !en_wr) |=> (st == ST_HOLD && en));
    a_r7_resume_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && en_wr) |=> (st == ST_RUN && !act));
endmodule

// File: rtl/dip_flag_unit.sv
module dip_flag_unit #(
    parameter int unsigned NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit,
    input  logic           clr,
    input  logic [NCH-1:0] pins,
    output logic           flag,
    output logic [NCH-1:0] stat
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            stat <= '0;
        end else begin
            if (hit) begin
                flag <= 1'b1;
                stat <= pins;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r11_stat_capture: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (stat == $past(pins)));
endmodule

// File: rtl/pwm_delayed_idle.sv
module pwm_delayed_idle
    import dip_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   set_req,
    input  logic [NUM_CH-1:0]   rst_req,
    input  logic                fault_in,
    input  logic                prot_en,
    input  logic [2:0]          mode,
    input  logic [NUM_CH-1:0]   idle_lvl,
    input  logic                oen_wr,
    input  logic [NUM_CH-1:0]   oen_data,
    input  logic                flag_clr,
    input  logic                irq_en,
    output logic [NUM_CH-1:0]   pwm_out,
    output logic [NUM_CH-1:0]   pwm_copy,
    output logic [NUM_CH-1:0]   out_en,
    output logic                evt_flag,
    output logic                irq,
    output logic [NUM_CH-1:0]   trip_stat
);
    logic              rise;
    logic              hit;
    logic [NUM_CH-1:0] sel;
    logic              mode_hi_unused;

    assign mode_hi_unused = mode[2];

    dip_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (fault_in),
        .rise     (rise)
    );

    assign hit = rise & prot_en;

    always_comb begin
        unique case (mode[1:0])
            2'b00:   sel = 2'b01;
            2'b01:   sel = 2'b10;
            2'b10:   sel = 2'b11;
            default: sel = 2'b00;
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dip_out_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_req  (set_req[i]),
            .rst_req  (rst_req[i]),
            .trip     (hit & sel[i]),
            .en_wr    (oen_wr & oen_data[i]),
            .idle_lvl (idle_lvl[i]),
            .pin      (pwm_out[i]),
            .en       (out_en[i])
        );
    end

    dip_flag_unit #(.NCH(NUM_CH)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .pins  (pwm_out),
        .flag  (evt_flag),
        .stat  (trip_stat)
    );

    assign pwm_copy = pwm_out;
    assign irq      = evt_flag & irq_en;

    a_r10_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && prot_en) |=> evt_flag);
    a_r3_gate_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !prot_en && !evt_flag) |=> !evt_flag);
endmodule

// File: tb/pwm_delayed_idle_test.sv
module pwm_delayed_idle_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] set_req = '0, rst_req = '0, idle_lvl = '0, oen_data = '0;
    logic       fault_in = 1'b0, prot_en = 1'b0, oen_wr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
    logic [2:0] mode = '0;
    logic [1:0] pwm_out, pwm_copy, out_en, trip_stat;
    logic       evt_flag, irq;
    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pwm_delayed_idle uut (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .rst_req(rst_req),
        .fault_in(fault_in), .prot_en(prot_en), .mode(mode), .idle_lvl(idle_lvl),
        .oen_wr(oen_wr), .oen_data(oen_data), .flag_clr(flag_clr), .irq_en(irq_en),
        .pwm_out(pwm_out), .pwm_copy(pwm_copy), .out_en(out_en),
        .evt_flag(evt_flag), .irq(irq), .trip_stat(trip_stat)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] selmask(input logic [2:0] m);
        case (m[1:0])
            2'b00: return 2'b01;
            2'b01: return 2'b10;
            2'b10: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; set_req = '0; rst_req = '0; fault_in = 1'b0;
        oen_wr = 1'b0; flag_clr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_req(input logic [1:0] s, input logic [1:0] r);
        set_req = s; rst_req = r;
        @(negedge clk);
        set_req = '0; rst_req = '0;
    endtask

    task automatic write_en(input logic [1:0] d);
        oen_wr = 1'b1; oen_data = d;
        @(negedge clk);
        oen_wr = 1'b0; oen_data = '0;
    endtask

    task automatic fire();
        fault_in = 1'b1;
        repeat (3) @(negedge clk);
        fault_in = 1'b0;
    endtask

    initial begin
        // sweep: protection enable x mode x idle level x starting active pattern
        for (int pe = 0; pe < 2; pe++) begin
            for (int m = 0; m < 8; m++) begin
                for (int il = 0; il < 4; il++) begin
                    for (int ap = 0; ap < 4; ap++) begin
                        logic [1:0] s, held, ilv, apv;
                        ilv = il[1:0]; apv = ap[1:0];
                        prot_en = pe[0]; mode = m[2:0]; idle_lvl = ilv; irq_en = 1'b1;
                        do_reset();
                        check("R1 enables", {6'd0, out_en}, 8'd0);
                        check("R1 pins", {4'd0, pwm_copy, pwm_out}, {4'd0, ilv, ilv});
                        check("R1 flag", {5'd0, evt_flag, trip_stat}, 8'd0);
                        write_en(2'b11);
                        check("R2 enable write", {6'd0, out_en}, 8'd3);
                        pulse_req(apv, 2'b00);
                        check("R2 set drives", {6'd0, pwm_out}, {6'd0, apv ^ ilv});
                        s = pe[0] ? selmask(m[2:0]) : 2'b00;
                        held = s & ~apv;
                        fire();
                        check("R4 R5 R8 at event", {6'd0, pwm_out}, {6'd0, apv ^ ilv});
                        check("R10 flag irq", {6'd0, irq, evt_flag}, {6'd0, pe[0], pe[0]});
                        check("R11 status", {6'd0, trip_stat}, {6'd0, pe[0] ? (apv ^ ilv) : 2'b00});
                        pulse_req(2'b11, 2'b00);
                        check("R5 R8 set after event", {6'd0, pwm_out}, {6'd0, ~held ^ ilv});
                        pulse_req(2'b00, 2'b11);
                        check("R4 reset ends pulse", {6'd0, pwm_out}, {6'd0, ilv});
                        check("R6 enables kept", {6'd0, out_en}, 8'd3);
                        pulse_req(2'b11, 2'b00);
                        check("R3 R5 held ignore set", {6'd0, pwm_out}, {6'd0, ~s ^ ilv});
                        write_en(2'b11);
                        check("R7 resume stays", {6'd0, pwm_out}, {6'd0, ~s ^ ilv});
                        pulse_req(2'b11, 2'b00);
                        check("R7 next set active", {6'd0, pwm_out}, {6'd0, ~ilv});
                        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
                        check("R10 clear", {6'd0, irq, evt_flag}, 8'd0);
                    end
                end
            end
        end

        // directed: fault edge in the same cycle as a reset request (both channels active)
        prot_en = 1'b1; mode = 3'b110; idle_lvl = 2'b00; irq_en = 1'b0;
        do_reset();
        write_en(2'b11);
        pulse_req(2'b11, 2'b00);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        rst_req = 2'b11;
        @(negedge clk);
        rst_req = 2'b00;
        check("R5 same-cycle reset idles", {6'd0, pwm_out}, 8'd0);
        check("R10 irq gated off", {6'd0, irq, evt_flag}, 8'd1);
        pulse_req(2'b11, 2'b00);
        check("R5 same-cycle reset then set ignored", {6'd0, pwm_out}, 8'd0);
        // line still high: no second event
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 level held acts once", {7'd0, evt_flag}, 8'd0);
        fault_in = 1'b0;

        // directed: fault with set request in same cycle while idle, plus flag clear
        do_reset();
        write_en(2'b11);
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        set_req = 2'b11; flag_clr = 1'b1;
        @(negedge clk);
        set_req = 2'b00; flag_clr = 1'b0; fault_in = 1'b0;
        check("R5 same-cycle set ignored", {6'd0, pwm_out}, 8'd0);
        check("R10 event beats clear", {7'd0, evt_flag}, 8'd1);

        // directed: sync latency, flag not yet set after two edges
        do_reset();
        fault_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 not before third edge", {7'd0, evt_flag}, 8'd0);
        @(negedge clk);
        check("R9 set on third edge", {7'd0, evt_flag}, 8'd1);
        fault_in = 1'b0;

        // directed: enable write while armed is ignored
        do_reset();
        idle_lvl = 2'b10;
        write_en(2'b11);
        pulse_req(2'b11, 2'b00);
        fire();
        write_en(2'b11);
        check("R4 armed stays active", {6'd0, pwm_out}, 8'd1);
        pulse_req(2'b00, 2'b11);
        pulse_req(2'b11, 2'b00);
        check("R4 early enable write ignored", {6'd0, pwm_out}, 8'd2);
        check("R2 copy matches", {6'd0, pwm_copy}, 8'd2);

        // directed: reset wins over set
        do_reset();
        idle_lvl = 2'b00;
        write_en(2'b11);
        pulse_req(2'b11, 2'b11);
        check("R2 reset wins", {6'd0, pwm_out}, 8'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule